// File: doc/BRIEF.md
# Multi-Rule Concurrent Grant Scheduler

This block decides, in a single cycle, which of a set of guarded actions ("rules") may take effect together. Each rule raises a can-fire request. A relation table, supplied as an input, classifies every pair of rules in one of four ways:
- conflicting;
- conflict-free;
- sequentially composable with the lower index ordered first;
- sequentially composable with the higher index ordered first.

The scheduler grants as many requests as it can without placing two incompatible rules in the same cycle. Among incompatible requests, the lower rule index has precedence.

The block also owns one register that several rules may write. When more than one granted rule writes it, the value is taken from the rule that comes last in the sequential order. Two conflict-free rules that both write the register are never granted together. Because of that, the merge is a plain AND-OR of the selected values.

Top module: `rule_sched`

## Requirements
- R1: A will_fire bit is only ever 1 when the matching can_fire bit is 1.
- R2: When any can_fire bit is 1, at least one will_fire bit is 1.
- R3: The relation of pair a<b is rel_tbl[2*(a*N+b)+:2]: 0 = conflicting, 1 = conflict-free, 2 = composable with a ordered before b, 3 = composable with b ordered before a. Entries with a>=b are ignored. Two rules of a pair coded 0 are never granted together.
- R4: The lowest-index requesting rule is always granted. A requesting rule is refused only when a granted rule of lower index clashes with it.
- R5: Requesting rules that do not clash with any granted lower-index rule are all granted in the same cycle.
- R6: Two rules of a pair coded 1 that both have their wr_mask bit set clash, and are never granted together.
- R7: reg_we is the OR over rules of will_fire AND wr_mask. reg_q takes reg_d at the next clock edge when reg_we is 1 and holds otherwise. reg_d equals reg_q when reg_we is 0.
- R8: When several granted rules write the register, reg_d is the wr_data of the writer that comes last in the sequential order given by codes 2 and 3.
- R9: A single granted writer passes its wr_data slice (rule i at bits [i*W+:W]) to reg_d.
- R10: While rst_n is 0, reg_q is RESET_VAL (default 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset for the shared register |
| can_fire | input | N | Per-rule request (rule predicate) |
| rel_tbl | input | 2*N*N | Pair relation codes, upper triangle used |
| wr_mask | input | N | Rule writes the shared register |
| wr_data | input | N*W | Per-rule value for the shared register |
| will_fire | output | N | Per-rule grant |
| reg_we | output | 1 | Shared register write enable |
| reg_d | output | W | Next value of the shared register |
| reg_q | output | W | Current value of the shared register |

## Verification
The grants, reg_we and reg_d are combinational, so they are due in the same cycle the inputs are applied. reg_q follows one clock edge later. The driver applies inputs just after a rising edge and queues the expected grants and next value. The monitor compares them at the following falling edge, before the register updates. reg_q is compared at that same falling edge against the value the bench's own model committed at the previous edge.

// File: rtl/rule_sched.sv
module rule_sched #(
  parameter int N = 4,
  parameter int W = 8,
  parameter logic [W-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     can_fire,
  input  logic [2*N*N-1:0] rel_tbl,
  input  logic [N-1:0]     wr_mask,
  input  logic [N*W-1:0]   wr_data,
  output logic [N-1:0]     will_fire,
  output logic             reg_we,
  output logic [W-1:0]     reg_d,
  output logic [W-1:0]     reg_q
);
  localparam logic [1:0] REL_CONF = 2'd0;
  localparam logic [1:0] REL_FREE = 2'd1;
  localparam logic [1:0] REL_LOFIRST = 2'd2;
  localparam logic [1:0] REL_HIFIRST = 2'd3;

  function automatic logic [1:0] rel(input int a, input int b);
    int lo, hi;
    lo = (a < b) ? a : b;
    hi = (a < b) ? b : a;
    return rel_tbl[2*(lo*N+hi) +: 2];
  endfunction

  function automatic logic clash(input int a, input int b);
    logic [1:0] c;
    c = rel(a, b);
    return (c == REL_CONF) || (c == REL_FREE && wr_mask[a] && wr_mask[b]);
  endfunction

  function automatic logic after(input int a, input int b);
    logic [1:0] c;
    c = rel(a, b);
    if (a < b) return c == REL_LOFIRST;
    return c == REL_HIFIRST;
  endfunction

  logic [N-1:0] grant;
  always_comb begin
    grant = '0;
    for (int i = 0; i < N; i++) begin
      grant[i] = can_fire[i];
      for (int j = 0; j < i; j++)
        if (grant[j] && clash(j, i)) grant[i] = 1'b0;
    end
  end

  logic [N-1:0] writing, winner;
  assign writing = grant & wr_mask;

  always_comb begin
    winner = writing;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if (i != j && writing[j] && after(i, j)) winner[i] = 1'b0;
  end

  logic [W-1:0] merged;
  always_comb begin
    merged = '0;
    for (int i = 0; i < N; i++)
      merged = merged | ({W{winner[i]}} & wr_data[i*W +: W]);
  end

  assign will_fire = grant;
  assign reg_we = |writing;
  assign reg_d = reg_we ? merged : reg_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) reg_q <= RESET_VAL;
    else if (reg_we) reg_q <= reg_d;
endmodule

// File: rtl/rule_sched_chk.sv
module rule_sched_chk #(
  parameter int N = 4,
  parameter int W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N-1:0]     can_fire,
  input logic [2*N*N-1:0] rel_tbl,
  input logic [N-1:0]     wr_mask,
  input logic [N-1:0]     will_fire,
  input logic             reg_we,
  input logic [W-1:0]     reg_d,
  input logic [W-1:0]     reg_q
);
  a_r1_grant_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    (will_fire & ~can_fire) == '0);
  a_r2_some_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (|can_fire) |-> (|will_fire));
  a_r4_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    can_fire[0] |-> will_fire[0]);
  a_r7_load: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> reg_q == $past(reg_d));
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> $stable(reg_q));
  a_r7_we_needs_writer: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (|(will_fire & wr_mask)));

  for (genvar a = 0; a < N; a++) begin : g_a
    for (genvar b = a + 1; b < N; b++) begin : g_b
      a_r3_conflict_pair: assert property (@(posedge clk) disable iff (!rst_n)
        rel_tbl[2*(a*N+b) +: 2] == 2'd0 |-> !(will_fire[a] && will_fire[b]));
      a_r6_free_writers: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_tbl[2*(a*N+b) +: 2] == 2'd1 && wr_mask[a] && wr_mask[b])
          |-> !(will_fire[a] && will_fire[b]));
    end
  end
endmodule

bind rule_sched rule_sched_chk #(.N(N), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .can_fire(can_fire), .rel_tbl(rel_tbl),
  .wr_mask(wr_mask), .will_fire(will_fire), .reg_we(reg_we),
  .reg_d(reg_d), .reg_q(reg_q));

// File: tb/sim_rule_sched.sv
module sim_rule_sched;
  localparam int N = 4;
  localparam int W = 8;

  logic clk = 0;
  logic rst_n = 0;
  logic [N-1:0] can_fire = '0;
  logic [2*N*N-1:0] rel_tbl = '0;
  logic [N-1:0] wr_mask = '0;
  logic [N*W-1:0] wr_data = '0;
  logic [N-1:0] will_fire;
  logic reg_we;
  logic [W-1:0] reg_d, reg_q;

  always #10 clk = ~clk;

  rule_sched #(.N(N), .W(W)) u0 (.*);

  typedef struct {
    logic [N-1:0] wf;
    logic we;
    logic [W-1:0] d;
    logic [W-1:0] q;
    string tag;
  } exp_t;

  exp_t sb[$];
  int errors = 0;
  int checks = 0;
  logic [W-1:0] model_q = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2*N*N-1:0] tbl(input logic [1:0] c01, c02, c03, c12, c13, c23);
    logic [2*N*N-1:0] t = '0;
    t[2:3-1+1] = '0;
    t[3:2] = c01; t[5:4] = c02; t[7:6] = c03;
    t[13:12] = c12; t[15:14] = c13; t[23:22] = c23;
    return t;
  endfunction

  task automatic drive(input logic [N-1:0] cf, input logic [2*N*N-1:0] t,
                       input logic [N-1:0] m, input logic [N-1:0] ewf,
                       input logic ewe, input logic [W-1:0] ed, input string tag);
    exp_t e;
    @(posedge clk);
    #2;
    can_fire = cf; rel_tbl = t; wr_mask = m;
    e.wf = ewf; e.we = ewe; e.d = ewe ? ed : model_q; e.q = model_q; e.tag = tag;
    sb.push_back(e);
    if (ewe) model_q = ed;
  endtask

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      chk({e.tag, " will_fire"}, 32'(will_fire), 32'(e.wf));
      chk({e.tag, " reg_we R7"}, 32'(reg_we), 32'(e.we));
      chk({e.tag, " reg_d"}, 32'(reg_d), 32'(e.d));
      chk({e.tag, " reg_q R7"}, 32'(reg_q), 32'(e.q));
    end
  end

  initial begin
    int cyc = 0;
    while (cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wr_data = {8'h08, 8'h07, 8'h06, 8'h05};
    repeat (2) @(posedge clk);
    #3;
    chk("R10 reset value", 32'(reg_q), 32'h0);
    @(posedge clk);
    #1;
    rst_n = 1;
    @(negedge clk);
    chk("R10 after release", 32'(reg_q), 32'h0);

    drive(4'b1111, tbl(1,1,1,1,1,1), 4'b0000, 4'b1111, 0, 0, "R5 all free");
    drive(4'b1110, tbl(0,0,0,0,0,0), 4'b0000, 4'b0010, 0, 0, "R4 R3 all conflict");
    wr_data = {8'h08, 8'h07, 8'h22, 8'h11};
    drive(4'b0011, tbl(0,1,1,1,1,1), 4'b0011, 4'b0001, 1, 8'h11, "R3 R9 xy pair");
    drive(4'b0000, tbl(0,1,1,1,1,1), 4'b0011, 4'b0000, 0, 0, "R2 R7 idle hold");
    drive(4'b1000, tbl(0,0,0,0,0,0), 4'b0000, 4'b1000, 0, 0, "R2 single request");
    @(posedge clk);
    #1;
    wr_data = {8'h08, 8'h07, 8'h06, 8'h05};
    drive(4'b0111, tbl(1,1,1,1,1,1), 4'b0101, 4'b0011, 1, 8'h05, "R6 free writers");
    drive(4'b0101, tbl(1,2,1,1,1,1), 4'b0101, 4'b0101, 1, 8'h07, "R8 lower first");
    drive(4'b0101, tbl(1,3,1,1,1,1), 4'b0101, 4'b0101, 1, 8'h05, "R8 higher first");
    drive(4'b1111, tbl(0,1,1,0,1,1), 4'b0000, 4'b1101, 0, 0, "R5 R4 mixed");
    drive(4'b0111, tbl(2,2,1,3,1,1), 4'b0111, 4'b0111, 1, 8'h06, "R8 three writers");
    drive(4'b0100, tbl(0,0,0,0,0,0), 4'b0100, 4'b0100, 1, 8'h07, "R9 lone writer");
    drive(4'b1010, tbl(1,1,1,1,0,1), 4'b0000, 4'b0010, 0, 0, "R3 R1 pair 1-3");
    drive(4'b0000, '0, 4'b0000, 4'b0000, 0, 0, "R7 final hold");

    repeat (3) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule